// File: doc/BRIEF.md
# Quad SPI Programmed-I/O Transfer Engine

This block is a half-duplex serial flash master that software drives entirely through register writes. Software first programs a control word holding the direction, the lane width, a chip-select hold flag and the chip-select choice. It then writes a byte count to a separate start register, and that write launches the transfer. Outgoing bytes are staged in a write FIFO, loaded one byte or four bytes at a time. The engine serialises them on one, two or four data lanes with a serial clock derived from the core clock. In the receive direction, each completed byte is presented on a one-cycle strobe.

A sticky interrupt status word reports four conditions: FIFO empty, FIFO full, a rejected push, and transfer completion. Each bit clears when software writes a 1 to it, and an enable mask gates the status bits onto one interrupt line. Setting the hold flag keeps chip select low once the last byte has gone. Several transfers, such as a command followed by its payload, can then form one frame on the wire.

Top module: `qspi_pio_engine`

## Requirements
- R1: After reset, both chip selects are high, the serial clock is low, no lane is driven, `rx_valid` and `irq` are low, the FIFO reports its full depth (16) as free space, and the status word holds only the empty bit (value 1).
- R2: The control register at address 0 holds the direction in bit 0 (1 = write, 0 = read), the lane code in bits 3:1, the hold flag in bit 4 and the chip-select choice in bit 5. A write to address 1 starts a transfer of exactly `wdata[15:0]` bytes, and a start write while a transfer is running is ignored.
- R3: Lane code 2 selects two lanes and code 3 selects four lanes; every other code (including 5, 6 and 7) runs a single lane. Bytes go out MSB first, each beat puts its least significant bit on lane 0, and single-lane mode sends on lane 0 and receives on lane 1.
- R4: One serial clock period spans four core clock cycles. The serial clock is low while no chip select is active, data changes after a falling edge, and data is sampled on the rising edge.
- R5: In a read transfer no lane is driven, and every received byte appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R6: Control bit 5 selects `cs_n[1]` (1) or `cs_n[0]` (0), and at most one chip select is ever low. With the hold flag clear, chip select rises when the transfer ends. With the flag set, chip select stays low into the next transfer.
- R7: A write to address 5 pushes `wdata[7:0]`, and a write to address 6 pushes four bytes in the order `wdata[7:0]` first through `wdata[31:24]` last. Address 2 reads the free FIFO byte count in bits 31:16 and the busy flag in bit 0.
- R8: A push that needs more room than the FIFO has free is dropped whole (a four-byte push needs four free bytes) and sets the overrun status bit.
- R9: A write transfer that finds the FIFO empty holds the serial clock low with chip select asserted until data arrives, then continues without losing bytes.
- R10: The status at address 3 has bit 0 empty, bit 1 full, bit 2 overrun and bit 3 done. Writing 1 to a bit clears it, but a condition present in that same cycle keeps it set.
- R11: `irq` is high exactly when some status bit and the matching enable bit at address 4 are both set.
- R12: A start with a count of zero sets the done bit without any serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| dq_out | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_in | input | 4 | Lane input values |
| rx_valid | output | 1 | Received-byte strobe |
| rx_data | output | 8 | Received byte |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of functions can act in the same cycle, and the bench provokes both.

The first pair is a software push and an engine pop of the write FIFO. A 40-byte quad transfer is started with an empty FIFO, and the bench then tops the FIFO up whenever the free count allows, so pushes keep landing on the cycles when the engine takes its next byte. The result is judged on the exact byte stream seen on the lanes.

The second pair is a write-one clear and a live set of the same status bit. The bench clears the empty bit while the FIFO is empty, and clears the full bit while the FIFO is full. It then checks that those bits read back as 1, while a cleared overrun bit, whose event has passed, reads back as 0.

// File: rtl/qspi_pio_pkg.sv
package qspi_pio_pkg;

   // register word addresses
   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_START  = 3'd1;
   localparam logic [2:0] A_XSTAT  = 3'd2;
   localparam logic [2:0] A_ISTAT  = 3'd3;
   localparam logic [2:0] A_IEN    = 3'd4;
   localparam logic [2:0] A_PUSH1  = 3'd5;
   localparam logic [2:0] A_PUSH4  = 3'd6;

   // status bit positions
   localparam int IB_EMPTY = 0;
   localparam int IB_FULL  = 1;
   localparam int IB_OVR   = 2;
   localparam int IB_DONE  = 3;
   localparam int IRQ_BITS = 4;

   typedef enum logic [1:0] {LW1 = 2'd0, LW2 = 2'd1, LW4 = 2'd2} lane_w_e;
   typedef enum logic [1:0] {S_IDLE = 2'd0, S_LOAD = 2'd1, S_SHIFT = 2'd2} xfer_st_e;

   function automatic lane_w_e code_to_width(input logic [2:0] code);
      case (code)
         3'd2:    return LW2;
         3'd3:    return LW4;
         default: return LW1;
      endcase
   endfunction

endpackage

// File: rtl/qspi_wfifo.sv
module qspi_wfifo #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          push_word,
   input  logic [31:0]   wdata,
   input  logic          pop,
   output logic [7:0]    rdata,
   output logic [AW:0]   level,
   output logic          rejected
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("qspi_wfifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   room, need;
   logic          accept;

   assign room     = (AW+1)'(DEPTH) - level;
   assign need     = push_word ? (AW+1)'(4) : (AW+1)'(1);
   assign accept   = push && (room >= need);
   assign rejected = push && !accept;
   assign rdata    = mem[rptr];

   always_ff @(posedge clk) begin
      if (accept) begin
         for (int i = 0; i < 4; i++) begin
            if ((AW+1)'(i) < need) mem[wptr + AW'(i)] <= wdata[8*i +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (accept) wptr <= wptr + need[AW-1:0];
         if (pop)    rptr <= rptr + AW'(1);
         level <= level + (accept ? need : '0) - (pop ? (AW+1)'(1) : '0);
      end
   end

   // R7
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (AW+1)'(DEPTH));

   // R8
   reject_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rejected && !pop) |=> level == $past(level));

endmodule

// File: rtl/qspi_lane_shifter.sv
module qspi_lane_shifter
   import qspi_pio_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int SCLK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   input  logic             cfg_write,
   input  logic [2:0]       cfg_lanes,
   input  logic             cfg_hold,
   input  logic             cfg_csel,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   output logic             fifo_pop,
   input  logic [3:0]       dq_in,
   output logic [3:0]       dq_out,
   output logic [3:0]       dq_oe,
   output logic             sclk,
   output logic [1:0]       cs_n,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             busy,
   output logic             done
);

   localparam int HALF = SCLK_DIV / 2;
   localparam int PW   = $clog2(SCLK_DIV);
   localparam logic [PW-1:0] PH_RISE = PW'(HALF - 1);
   localparam logic [PW-1:0] PH_LAST = PW'(SCLK_DIV - 1);

   generate
      if (SCLK_DIV < 4 || (SCLK_DIV % 2) != 0) begin : g_bad_div
         $error("qspi_lane_shifter: SCLK_DIV must be even and at least 4");
      end
   endgenerate

   xfer_st_e         st;
   lane_w_e          width_q;
   logic [CNT_W-1:0] remain;
   logic             wr_q, hold_q, csel_q, cs_act;
   logic [PW-1:0]    phase;
   logic [2:0]       beat, last_beat;
   logic [7:0]       tx_sh, tx_next, rx_sh, rx_next;
   logic [3:0]       lane_mask;

   always_comb begin
      case (width_q)
         LW2:     begin last_beat = 3'd3; tx_next = {tx_sh[5:0], 2'b00};
                        rx_next = {rx_sh[5:0], dq_in[1:0]}; lane_mask = 4'b0011;
                        dq_out = {2'b00, tx_sh[7:6]}; end
         LW4:     begin last_beat = 3'd1; tx_next = {tx_sh[3:0], 4'b0000};
                        rx_next = {rx_sh[3:0], dq_in}; lane_mask = 4'b1111;
                        dq_out = tx_sh[7:4]; end
         default: begin last_beat = 3'd7; tx_next = {tx_sh[6:0], 1'b0};
                        rx_next = {rx_sh[6:0], dq_in[1]}; lane_mask = 4'b0001;
                        dq_out = {3'b000, tx_sh[7]}; end
      endcase
   end

   assign busy     = (st != S_IDLE);
   assign fifo_pop = (st == S_LOAD) && wr_q && !fifo_empty;
   assign sclk     = (st == S_SHIFT) && (phase > PH_RISE);
   assign dq_oe    = (busy && wr_q) ? lane_mask : 4'b0000;
   assign cs_n     = cs_act ? ~(2'b01 << csel_q) : 2'b11;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         width_q  <= LW1;
         remain   <= '0;
         wr_q     <= 1'b0;
         hold_q   <= 1'b0;
         csel_q   <= 1'b0;
         cs_act   <= 1'b0;
         phase    <= '0;
         beat     <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         done     <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         done     <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  if (count == '0) begin
                     done <= 1'b1;
                     if (!cfg_hold) cs_act <= 1'b0;
                  end else begin
                     remain  <= count;
                     wr_q    <= cfg_write;
                     width_q <= code_to_width(cfg_lanes);
                     hold_q  <= cfg_hold;
                     if (!cs_act) csel_q <= cfg_csel;
                     cs_act  <= 1'b1;
                     st      <= S_LOAD;
                  end
               end
            end
            S_LOAD: begin
               if (!wr_q || !fifo_empty) begin
                  tx_sh <= wr_q ? fifo_data : 8'h00;
                  phase <= '0;
                  beat  <= '0;
                  st    <= S_SHIFT;
               end
            end
            S_SHIFT: begin
               if (phase == PH_RISE) rx_sh <= rx_next;
               if (phase == PH_LAST) begin
                  phase <= '0;
                  if (beat == last_beat) begin
                     if (!wr_q) begin
                        rx_valid <= 1'b1;
                        rx_data  <= rx_sh;
                     end
                     remain <= remain - CNT_W'(1);
                     if (remain == CNT_W'(1)) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                        if (!hold_q) cs_act <= 1'b0;
                     end else begin
                        st <= S_LOAD;
                     end
                  end else begin
                     beat  <= beat + 3'd1;
                     tx_sh <= tx_next;
                  end
               end else begin
                  phase <= phase + PW'(1);
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R4
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n == 2'b11) |-> !sclk);

   // R4
   sclk_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |=> !sclk);

   // R6
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R5
   read_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (dq_oe == 4'b0000));

   // R12
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/qspi_irq_ctrl.sv
module qspi_irq_ctrl #(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_we,
   input  logic [NB-1:0] clr_mask,
   input  logic          en_we,
   input  logic [NB-1:0] en_val,
   input  logic [NB-1:0] set,
   output logic [NB-1:0] stat,
   output logic [NB-1:0] en,
   output logic          irq
);

   assign irq = |(stat & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (en_we) en <= en_val;
   end

   for (genvar b = 0; b < NB; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    stat[b] <= 1'b0;
         else if (set[b])               stat[b] <= 1'b1;
         else if (clr_we && clr_mask[b]) stat[b] <= 1'b0;
      end

      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set[b] |=> stat[b]);
   end

   // R11
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

endmodule

// File: rtl/qspi_pio_engine.sv
module qspi_pio_engine
   import qspi_pio_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = 16,
   parameter int SCLK_DIV   = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        sclk,
   output logic [1:0]  cs_n,
   output logic [3:0]  dq_out,
   output logic [3:0]  dq_oe,
   input  logic [3:0]  dq_in,
   output logic        rx_valid,
   output logic [7:0]  rx_data,
   output logic        irq
);

   generate
      if (CNT_W > 16 || FIFO_DEPTH > 32768) begin : g_bad_width
         $error("qspi_pio_engine: count or depth exceeds the 16-bit register fields");
      end
   endgenerate

   logic [5:0]          ctrl_q;
   logic                start, push, push_word, rejected;
   logic                fifo_pop, fifo_empty, busy, done;
   logic [7:0]          fifo_data;
   logic [LVL_W-1:0]    level;
   logic [15:0]         free_bytes;
   logic [IRQ_BITS-1:0] ist, ien, iset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ctrl_q <= '0;
      else if (reg_we && reg_addr == A_CTRL)     ctrl_q <= reg_wdata[5:0];
   end

   assign start      = reg_we && (reg_addr == A_START);
   assign push       = reg_we && (reg_addr == A_PUSH1 || reg_addr == A_PUSH4);
   assign push_word  = (reg_addr == A_PUSH4);
   assign fifo_empty = (level == '0);
   assign free_bytes = 16'(FIFO_DEPTH) - 16'(level);

   always_comb begin
      iset           = '0;
      iset[IB_EMPTY] = fifo_empty;
      iset[IB_FULL]  = (level == LVL_W'(FIFO_DEPTH));
      iset[IB_OVR]   = rejected;
      iset[IB_DONE]  = done;
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = {26'b0, ctrl_q};
         A_XSTAT: reg_rdata = {free_bytes, 15'b0, busy};
         A_ISTAT: reg_rdata = {{(32-IRQ_BITS){1'b0}}, ist};
         A_IEN:   reg_rdata = {{(32-IRQ_BITS){1'b0}}, ien};
         default: reg_rdata = 32'h0;
      endcase
   end

   qspi_wfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_word (push_word),
      .wdata     (reg_wdata),
      .pop       (fifo_pop),
      .rdata     (fifo_data),
      .level     (level),
      .rejected  (rejected)
   );

   qspi_lane_shifter #(.CNT_W(CNT_W), .SCLK_DIV(SCLK_DIV)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .count      (reg_wdata[CNT_W-1:0]),
      .cfg_write  (ctrl_q[0]),
      .cfg_lanes  (ctrl_q[3:1]),
      .cfg_hold   (ctrl_q[4]),
      .cfg_csel   (ctrl_q[5]),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_data),
      .fifo_pop   (fifo_pop),
      .dq_in      (dq_in),
      .dq_out     (dq_out),
      .dq_oe      (dq_oe),
      .sclk       (sclk),
      .cs_n       (cs_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .busy       (busy),
      .done       (done)
   );

   qspi_irq_ctrl #(.NB(IRQ_BITS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (reg_we && reg_addr == A_ISTAT),
      .clr_mask (reg_wdata[IRQ_BITS-1:0]),
      .en_we    (reg_we && reg_addr == A_IEN),
      .en_val   (reg_wdata[IRQ_BITS-1:0]),
      .set      (iset),
      .stat     (ist),
      .en       (ien),
      .irq      (irq)
   );

   // R2
   start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> !done);

   // R8
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rejected |=> ist[IB_OVR]);

endmodule

// File: tb/sim_qspi_pio_engine.sv
`timescale 1ns/1ps
module sim_qspi_pio_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        sclk;
   logic [1:0]  cs_n;
   logic [3:0]  dq_out, dq_oe, dq_in;
   logic        rx_valid;
   logic [7:0]  rx_data;
   logic        irq;

   always #4 clk = ~clk;

   qspi_pio_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_n(cs_n),
      .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rx_valid(rx_valid),
      .rx_data(rx_data), .irq(irq)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   bit reported = 0;

   // bench flash model state
   int        cap_w = 1;
   logic [7:0] cap_sh;
   int        cap_nb = 0, cap_n = 0, rises = 0, cs_rise = 0;
   logic [7:0] cap_mem [64];
   logic [3:0] oe_seen = 4'h0;
   time       t_rise [2];
   int        rd_beat = 0;
   logic [7:0] rx_got [64];
   int        rx_n = 0;

   // mode, dir(1=write), hold, count
   localparam logic [12:0] VEC [9] = '{
      {3'd1, 1'b1, 1'b0, 8'd5},
      {3'd2, 1'b1, 1'b0, 8'd6},
      {3'd3, 1'b1, 1'b0, 8'd9},
      {3'd1, 1'b0, 1'b0, 8'd3},
      {3'd2, 1'b0, 1'b0, 8'd4},
      {3'd3, 1'b0, 1'b0, 8'd7},
      {3'd3, 1'b1, 1'b1, 8'd2},
      {3'd3, 1'b1, 1'b0, 8'd3},
      {3'd5, 1'b1, 1'b0, 8'd2}
   };

   function automatic int width_of(input logic [2:0] code);
      return (code == 3'd2) ? 2 : (code == 3'd3) ? 4 : 1;
   endfunction
   function automatic logic [7:0] tx_pat(input int s, input int k);
      return 8'((s * 53 + k * 29 + 7) & 255);
   endfunction
   function automatic logic [7:0] rd_pat(input int k);
      return 8'hC3 ^ 8'((k * 37) & 255);
   endfunction
   function automatic logic [3:0] lane_mask(input int w);
      return (w == 4) ? 4'hF : (w == 2) ? 4'h3 : 4'h1;
   endfunction

   always @(posedge sclk) begin
      if (rises < 2 && rises >= 0) t_rise[rises] = $time;
      rises   = rises + 1;
      oe_seen = oe_seen | dq_oe;
      case (cap_w)
         4:       cap_sh = {cap_sh[3:0], dq_out};
         2:       cap_sh = {cap_sh[5:0], dq_out[1:0]};
         default: cap_sh = {cap_sh[6:0], dq_out[0]};
      endcase
      cap_nb = cap_nb + cap_w;
      if (cap_nb >= 8) begin
         if (cap_n < 64) cap_mem[cap_n] = cap_sh;
         cap_n  = cap_n + 1;
         cap_nb = 0;
      end
   end

   always @(negedge sclk) rd_beat = rd_beat + 1;
   always @(posedge cs_n[0]) cs_rise = cs_rise + 1;

   always_comb begin
      int bpb, bt;
      logic [7:0] b;
      bpb   = 8 / cap_w;
      b     = rd_pat(rd_beat / bpb);
      bt    = rd_beat % bpb;
      dq_in = 4'h0;
      case (cap_w)
         4:       dq_in = (bt == 0) ? b[7:4] : b[3:0];
         2:       dq_in = {2'b00, b[7 - 2*bt -: 2]};
         default: dq_in = {2'b00, b[7 - bt], 1'b0};
      endcase
   end

   always @(negedge clk) begin
      if (rx_valid) begin
         if (rx_n < 64) rx_got[rx_n] = rx_data;
         rx_n = rx_n + 1;
      end
   end

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      end
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000 && !reported) begin
         n_chk = n_chk + 1;
         n_err = n_err + 1;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         report();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_err = n_err + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic model_reset(input int w);
      cap_w = w; cap_nb = 0; cap_n = 0; rises = 0; rd_beat = 0; rx_n = 0; oe_seen = 4'h0;
   endtask

   task automatic push_bytes(input int s, input int first, input int n);
      int k;
      k = first;
      while (k < first + n) begin
         if (first + n - k >= 4) begin
            wr(3'd6, {tx_pat(s, k+3), tx_pat(s, k+2), tx_pat(s, k+1), tx_pat(s, k)});
            k = k + 4;
         end else begin
            wr(3'd5, {24'h0, tx_pat(s, k)});
            k = k + 1;
         end
      end
   endtask

   task automatic wait_done(input string req);
      logic [31:0] v;
      int t;
      t = 0;
      v = 0;
      while (v[3] == 1'b0 && t < 5000) begin
         rd(3'd3, v);
         t = t + 1;
      end
      chk(v[3] == 1'b1, req, v, 32'h8);
   endtask

   task automatic cmp_tx(input string req, input int s, input int n);
      int bad;
      bad = (cap_n == n) ? 0 : 1;
      for (int k = 0; k < n && k < cap_n; k++) if (cap_mem[k] !== tx_pat(s, k)) bad = bad + 1;
      chk(bad == 0, req, 32'(cap_n), 32'(n));
   endtask

   task automatic cmp_rx(input string req, input int n);
      int bad;
      bad = (rx_n == n) ? 0 : 1;
      for (int k = 0; k < n && k < rx_n; k++) if (rx_got[k] !== rd_pat(k)) bad = bad + 1;
      chk(bad == 0, req, 32'(rx_n), 32'(n));
   endtask

   initial begin
      logic [31:0] v;
      int f, k, t;

      // ---------- reset state (R1) ----------
      idle(3);
      rst_n = 1'b1;
      idle(3);
      chk(cs_n == 2'b11 && sclk == 1'b0 && dq_oe == 4'h0 && !irq && !rx_valid,
          "R1 pins", {cs_n, sclk, dq_oe, irq, rx_valid}, {2'b11, 7'b0});
      rd(3'd2, v);
      chk(v == {16'd16, 16'h0}, "R1 R7 free after reset", v, {16'd16, 16'h0});
      rd(3'd3, v);
      chk(v == 32'h1, "R1 status after reset", v, 32'h1);

      // ---------- clear while empty persists (R10) ----------
      wr(3'd3, 32'h1);
      rd(3'd3, v);
      chk(v[0] == 1'b1, "R10 empty set wins over clear", v, 32'h1);

      // ---------- interrupt masking (R11) ----------
      chk(irq == 1'b0, "R11 masked irq", {31'b0, irq}, 32'h0);
      wr(3'd4, 32'h1);
      chk(irq == 1'b1, "R11 enabled irq", {31'b0, irq}, 32'h1);
      wr(3'd4, 32'h8);
      wr(3'd3, 32'h8);
      chk(irq == 1'b0, "R11 done-only mask", {31'b0, irq}, 32'h0);
      wr(3'd4, 32'h0);

      // ---------- vector table (R2 R3 R4 R5 R6) ----------
      for (int vi = 0; vi < 9; vi++) begin
         logic [2:0] code;
         logic dir, hold;
         int n, w;
         code = VEC[vi][12:10];
         dir  = VEC[vi][9];
         hold = VEC[vi][8];
         n    = int'(VEC[vi][7:0]);
         w    = width_of(code);
         wr(3'd0, {26'b0, 1'b0, hold, code, dir});
         model_reset(w);
         if (dir) push_bytes(vi, 0, n);
         if (vi == 0) begin
            rd(3'd2, v);
            chk(v[31:16] == 16'd11, "R7 free after 5 bytes", v, {16'd11, 16'h0});
         end
         wr(3'd3, 32'h8);
         wr(3'd1, n);
         wait_done("R2 transfer done");
         if (dir) begin
            cmp_tx("R3 lane stream", vi, n);
            chk(oe_seen == lane_mask(w), "R3 lane enables", {28'b0, oe_seen}, {28'b0, lane_mask(w)});
         end else begin
            cmp_rx("R5 received bytes", n);
            chk(oe_seen == 4'h0, "R5 lanes undriven", {28'b0, oe_seen}, 32'h0);
         end
         chk(cs_n[0] == !hold, "R6 cs after transfer", {30'b0, cs_n}, {30'b0, 1'b1, !hold});
         if (vi == 0) chk(t_rise[1] - t_rise[0] == 32, "R4 sclk period", 32'(t_rise[1] - t_rise[0]), 32'd32);
         if (vi == 7) chk(sclk == 1'b0, "R4 sclk idles low", {31'b0, sclk}, 32'h0);
      end

      // ---------- overrun and full (R8 R10) ----------
      wr(3'd0, {26'b0, 1'b0, 1'b0, 3'd3, 1'b1});
      wr(3'd3, 32'hF);
      push_bytes(9, 0, 14);
      wr(3'd6, 32'hDEADBEEF);
      rd(3'd2, v);
      chk(v[31:16] == 16'd2, "R8 word dropped whole", v, {16'd2, 16'h0});
      rd(3'd3, v);
      chk(v[2] == 1'b1, "R8 overrun set", v, 32'h4);
      push_bytes(9, 14, 2);
      wr(3'd5, 32'h55);
      wr(3'd3, 32'h6);
      rd(3'd3, v);
      chk(v[2:1] == 2'b01, "R10 full kept overrun cleared", v, 32'h2);
      model_reset(4);
      wr(3'd3, 32'h8);
      wr(3'd1, 32'd16);
      wait_done("R8 drain done");
      cmp_tx("R8 dropped data absent", 9, 16);

      // ---------- zero count (R12) ----------
      wr(3'd3, 32'hF);
      model_reset(1);
      wr(3'd1, 32'd0);
      idle(4);
      rd(3'd3, v);
      chk(v[3] == 1'b1 && rises == 0 && cs_n == 2'b11, "R12 zero count", {v[3], 31'(rises)}, 32'h80000000);

      // ---------- stall on empty FIFO (R9) ----------
      wr(3'd0, {26'b0, 1'b0, 1'b0, 3'd2, 1'b1});
      model_reset(2);
      wr(3'd3, 32'h8);
      wr(3'd1, 32'd2);
      idle(20);
      rd(3'd2, v);
      chk(rises == 0 && cs_n == 2'b10 && v[0] == 1'b1, "R9 stalled", 32'(rises), 32'h0);
      push_bytes(10, 0, 2);
      wait_done("R9 resumed done");
      cmp_tx("R9 stream after stall", 10, 2);

      // ---------- start while busy ignored (R2) ----------
      wr(3'd0, {26'b0, 1'b0, 1'b0, 3'd3, 1'b0});
      model_reset(4);
      wr(3'd3, 32'h8);
      wr(3'd1, 32'd3);
      wr(3'd1, 32'd9);
      wait_done("R2 first done");
      idle(60);
      rd(3'd2, v);
      cmp_rx("R2 second start ignored", 3);
      chk(v[0] == 1'b0, "R2 idle after", v, 32'h0);

      // ---------- second chip select (R6) ----------
      wr(3'd0, {26'b0, 1'b1, 1'b0, 3'd1, 1'b1});
      model_reset(1);
      push_bytes(11, 0, 1);
      wr(3'd3, 32'h8);
      wr(3'd1, 32'd1);
      idle(4);
      chk(cs_n == 2'b01, "R6 cs1 active", {30'b0, cs_n}, 32'h1);
      wait_done("R6 done");
      chk(cs_n == 2'b11, "R6 cs1 released", {30'b0, cs_n}, 32'h3);
      cmp_tx("R6 byte on cs1", 11, 1);

      // ---------- push and pop in the same cycles (R7 R3) ----------
      wr(3'd0, {26'b0, 1'b0, 1'b0, 3'd3, 1'b1});
      model_reset(4);
      wr(3'd3, 32'hF);
      wr(3'd1, 32'd40);
      k = 0; t = 0;
      while (k < 40 && t < 4000) begin
         rd(3'd2, v);
         f = int'(v[31:16]);
         if (f >= 4 && 40 - k >= 4) begin
            push_bytes(12, k, 4);
            k = k + 4;
         end else if (f >= 1) begin
            push_bytes(12, k, 1);
            k = k + 1;
         end
         t = t + 1;
      end
      wait_done("R7 streaming done");
      cmp_tx("R7 streamed bytes", 12, 40);
      rd(3'd3, v);
      chk(v[2] == 1'b0, "R8 no overrun while streaming", v, 32'h0);

      report();
      $finish;
   end

endmodule